// File: doc/BRIEF.md
# Host Bus Address Latch and Decoder

This block is the host-facing front end of a peripheral's register file. It qualifies the incoming host address with an address-enable input and can hold it in a latch that loads on the rising edge of an active-low address strobe. The upper address bits are compared with a programmable base to produce a device select, and the low address bits give the register index inside the selected window. A second comparator works on the unlatched bus and provides a live local-device select, for bus logic that must answer before the strobe arrives.

On the synchronous side, a cycle input that is low marks a data transfer. The block turns each transfer into a registered write or read pulse together with per-byte-lane strobes and the register index. A mode input selects local-bus operation, where each low stretch of the cycle input gives exactly one transfer, or burst-DMA operation, where every clock of the stretch gives one transfer. While the active-low data chip-select is asserted, the byte enables are overridden and every lane is strobed. The raw reset input first passes through a counter-based glitch filter that runs on the local clock.

Top module: `hbus_front`

## Requirements
- R1: The block enters reset only after `rst_n_raw` has been sampled low on RST_CYCLES (default 5, which is 100 ns at 50 MHz) consecutive rising clock edges. It stays in reset through the first edge at which `rst_n_raw` is sampled high and runs normally from the edge after that. A shorter low pulse leaves all state unchanged.
- R2: `live_sel` is high exactly when the live `aen` is low and live `addr[15:4]` equals `base_addr`. It follows the bus combinationally, with no latching.
- R3: At a clock edge where `addr_stb_n` is sampled high after being sampled low at the previous edge, `addr[15:1]` and `aen` are captured. Until the next such edge, `dev_sel` and `reg_idx` depend only on the captured values and do not follow changes on the live bus.
- R4: `dev_sel` is high exactly when the captured address enable is low and the captured `addr[15:4]` equals `base_addr`.
- R5: `reg_idx` equals captured `addr[3:1]`.
- R6: When `data_cs_n` is high, a transfer's `xfer_lanes` bit i is high when `be_n` bit i was low at the sampling edge.
- R7: When `data_cs_n` is low, a transfer strobes all lanes (`xfer_lanes` all ones) whatever `be_n` holds.
- R8: A transfer whose `wr_rd` was sampled high pulses `xfer_wr`. One whose `wr_rd` was sampled low pulses `xfer_rd`. The two are never high together, and `xfer_lanes` and `xfer_idx` are zero when neither is high.
- R9: With `mode_n` low (local-bus mode), a transfer occurs only at an edge where `cyc_n` is sampled low and was sampled high at the previous edge. The pulse is visible for the one cycle after that edge.
- R10: With `mode_n` high (burst-DMA mode), a transfer occurs at every edge where `cyc_n` is sampled low.
- R11: No transfer occurs unless `dev_sel` is high or `data_cs_n` is low at the sampling edge.
- R12: In reset, the transfer outputs are zero, the captured enable reads as inactive (`dev_sel` low), and `reg_idx` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local synchronous bus clock |
| rst_n_raw | input | 1 | Unfiltered active-low reset |
| base_addr | input | 12 | Device window base, compared with addr[15:4] |
| addr | input | 15 | Host address bits 15..1 |
| aen | input | 1 | Address enable, decoding allowed while low |
| addr_stb_n | input | 1 | Active-low address strobe, latches on its rising edge |
| be_n | input | 4 | Active-low byte enables, one per lane |
| data_cs_n | input | 1 | Active-low burst data select, forces all lanes |
| cyc_n | input | 1 | Active-low synchronous cycle marker |
| wr_rd | input | 1 | Direction, high for write, low for read |
| mode_n | input | 1 | Low selects local-bus mode, high burst-DMA mode |
| live_sel | output | 1 | Device select decoded from the unlatched bus |
| dev_sel | output | 1 | Device select decoded from the captured address |
| reg_idx | output | 3 | Register index from the captured address |
| xfer_wr | output | 1 | One-cycle write transfer pulse |
| xfer_rd | output | 1 | One-cycle read transfer pulse |
| xfer_lanes | output | 4 | Byte-lane strobes of the current transfer |
| xfer_idx | output | 3 | Register index of the current transfer |

## Verification
The assertions assume that every input is synchronous to `clk` and stable around each rising edge. They also assume that nothing the block did before its first filtered reset matters, so each property waits until a reset has been seen. The bench drives all inputs just after the falling edge. It applies a full-length reset before any check, keeps random reset pulses rare, and picks the window bits equal to the base about half the time, so hits and misses both occur while strobe, cycle, mode and burst select change independently.

// File: rtl/hbus_pkg.sv
// Shared definitions for the host bus front end.
// Assumes: nothing beyond SystemVerilog 2017 packages.
package hbus_pkg;

    // Synchronous transfer pacing selected by the mode input.
    typedef enum logic {
        PACE_SINGLE = 1'b0,   // one transfer per cycle-marker stretch
        PACE_STREAM = 1'b1    // one transfer per clock while marked
    } pace_t;

    // Maps the active-low mode pin onto the pacing type.
    function automatic pace_t pace_from_pin(input logic mode_n);
        return mode_n ? PACE_STREAM : PACE_SINGLE;
    endfunction

endpackage

// File: rtl/hbus_rst_filter.sv
// Reset glitch filter: asserts the internal active-low reset only after the
// raw reset has been sampled low on CYCLES consecutive clock edges.
// Assumes: CYCLES >= 1 and clk is free-running while reset is applied.
module hbus_rst_filter #(
    parameter int CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n_raw,
    output logic rst_n
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(CYCLES);

    logic [CNT_W-1:0] low_cnt;

    // Count consecutive low samples, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (rst_n_raw) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_MAX) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Reset is in force while the count sits at the threshold.
    assign rst_n = (low_cnt != CNT_MAX);

endmodule

// File: rtl/hbus_addr_latch.sv
// Address capture stage: loads the address and address enable when the
// sampled strobe goes from low to high, or passes them straight through
// when LATCH_EN is 0.
// Assumes: strobe and address are synchronous to clk.
module hbus_addr_latch #(
    parameter int ADDR_HI  = 15,
    parameter bit LATCH_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADDR_HI:1] addr,
    input  logic             aen,
    input  logic             stb_n,
    output logic [ADDR_HI:1] cap_addr,
    output logic             cap_aen
);
    generate
        if (LATCH_EN) begin : g_latched
            logic             stb_q;
            logic             load;
            logic [ADDR_HI:1] addr_q;
            logic             aen_q;

            // Low-to-high strobe transition seen across two samples.
            assign load = !stb_q && stb_n;

            // Track the previous strobe sample.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stb_q <= 1'b1;
                end else begin
                    stb_q <= stb_n;
                end
            end

            // Capture address and qualifier on the strobe transition.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_q <= '0;
                    aen_q  <= 1'b1;
                end else if (load) begin
                    addr_q <= addr;
                    aen_q  <= aen;
                end
            end

            assign cap_addr = addr_q;
            assign cap_aen  = aen_q;
        end else begin : g_transparent
            assign cap_addr = addr;
            assign cap_aen  = aen;
        end
    endgenerate

endmodule

// File: rtl/hbus_window_match.sv
// Window comparator: reports a hit when the qualifier is low and the upper
// address bits equal the programmed base.
// Assumes: the base is held steady by its owner.
module hbus_window_match #(
    parameter int BASE_W = 12
) (
    input  logic [BASE_W-1:0] base,
    input  logic [BASE_W-1:0] upper,
    input  logic              aen,
    output logic              hit
);
    // Combined qualifier and equality compare.
    always_comb begin
        hit = !aen && (upper == base);
    end

endmodule

// File: rtl/hbus_xfer_ctrl.sv
// Transfer generator: turns sampled cycle markers into registered write or
// read pulses with byte-lane strobes and the register index.
// Assumes: dev_sel and reg_idx come from the capture stage of the same clock.
module hbus_xfer_ctrl
    import hbus_pkg::*;
#(
    parameter int LANES = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_n,
    input  logic             wr_rd,
    input  logic             mode_n,
    input  logic             dcs_n,
    input  logic [LANES-1:0] be_n,
    input  logic             dev_sel,
    input  logic [IDX_W-1:0] reg_idx,
    output logic             xfer_wr,
    output logic             xfer_rd,
    output logic [LANES-1:0] xfer_lanes,
    output logic [IDX_W-1:0] xfer_idx
);
    pace_t            pace;
    logic             cyc_q;
    logic             qualified;
    logic             fire;
    logic [LANES-1:0] lane_sel;

    assign pace = pace_from_pin(mode_n);

    // Per-lane select: burst data select overrides the byte enable.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_sel[i] = !dcs_n || !be_n[i];
        end
    endgenerate

    // Decide whether the present edge launches a transfer.
    always_comb begin
        qualified = dev_sel || !dcs_n;
        fire      = 1'b0;
        if (!cyc_n && qualified) begin
            unique case (pace)
                PACE_STREAM: fire = 1'b1;
                PACE_SINGLE: fire = cyc_q;
                default:     fire = 1'b0;
            endcase
        end
    end

    // Remember the previous cycle-marker sample for single pacing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= 1'b1;
        end else begin
            cyc_q <= cyc_n;
        end
    end

    // Register the transfer pulse and its attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_wr    <= 1'b0;
            xfer_rd    <= 1'b0;
            xfer_lanes <= '0;
            xfer_idx   <= '0;
        end else begin
            xfer_wr    <= fire && wr_rd;
            xfer_rd    <= fire && !wr_rd;
            xfer_lanes <= fire ? lane_sel : '0;
            xfer_idx   <= fire ? reg_idx : '0;
        end
    end

endmodule

// File: rtl/hbus_front.sv
// Host bus front end: reset filter, address capture, live and captured
// window decode, and synchronous transfer generation.
// Assumes: all bus inputs are synchronous to clk; base_addr is quasi-static.
module hbus_front #(
    parameter int ADDR_HI    = 15,
    parameter int IDX_W      = 3,
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 5,
    parameter bit LATCH_EN   = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n_raw,
    input  logic [ADDR_HI-IDX_W-1:0]     base_addr,
    input  logic [ADDR_HI:1]             addr,
    input  logic                         aen,
    input  logic                         addr_stb_n,
    input  logic [DATA_W/8-1:0]          be_n,
    input  logic                         data_cs_n,
    input  logic                         cyc_n,
    input  logic                         wr_rd,
    input  logic                         mode_n,
    output logic                         live_sel,
    output logic                         dev_sel,
    output logic [IDX_W-1:0]             reg_idx,
    output logic                         xfer_wr,
    output logic                         xfer_rd,
    output logic [DATA_W/8-1:0]          xfer_lanes,
    output logic [IDX_W-1:0]             xfer_idx
);
    localparam int BASE_W = ADDR_HI - IDX_W;
    localparam int LANES  = DATA_W / 8;

    logic             rst_n;
    logic [ADDR_HI:1] cap_addr;
    logic             cap_aen;

    hbus_rst_filter #(
        .CYCLES (RST_CYCLES)
    ) u_rst (
        .clk       (clk),
        .rst_n_raw (rst_n_raw),
        .rst_n     (rst_n)
    );

    hbus_addr_latch #(
        .ADDR_HI  (ADDR_HI),
        .LATCH_EN (LATCH_EN)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .aen      (aen),
        .stb_n    (addr_stb_n),
        .cap_addr (cap_addr),
        .cap_aen  (cap_aen)
    );

    hbus_window_match #(
        .BASE_W (BASE_W)
    ) u_live_match (
        .base  (base_addr),
        .upper (addr[ADDR_HI:IDX_W+1]),
        .aen   (aen),
        .hit   (live_sel)
    );

    hbus_window_match #(
        .BASE_W (BASE_W)
    ) u_cap_match (
        .base  (base_addr),
        .upper (cap_addr[ADDR_HI:IDX_W+1]),
        .aen   (cap_aen),
        .hit   (dev_sel)
    );

    assign reg_idx = cap_addr[IDX_W:1];

    hbus_xfer_ctrl #(
        .LANES (LANES),
        .IDX_W (IDX_W)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_n      (cyc_n),
        .wr_rd      (wr_rd),
        .mode_n     (mode_n),
        .dcs_n      (data_cs_n),
        .be_n       (be_n),
        .dev_sel    (dev_sel),
        .reg_idx    (reg_idx),
        .xfer_wr    (xfer_wr),
        .xfer_rd    (xfer_rd),
        .xfer_lanes (xfer_lanes),
        .xfer_idx   (xfer_idx)
    );

endmodule

// File: rtl/hbus_front_chk.sv
// Property checker for the host bus front end, bound into every instance.
// Assumes: properties are meaningful only after the first filtered reset.
module hbus_front_chk #(
    parameter int LANES = 4,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_stb_n,
    input logic [LANES-1:0] be_n,
    input logic             data_cs_n,
    input logic             cyc_n,
    input logic             mode_n,
    input logic             dev_sel,
    input logic [IDX_W-1:0] reg_idx,
    input logic             xfer_wr,
    input logic             xfer_rd,
    input logic [LANES-1:0] xfer_lanes
);
    logic armed;

    initial armed = 1'b0;

    // Arm the properties once a filtered reset has been observed.
    always @(posedge clk) begin
        if (!rst_n) armed <= 1'b1;
    end

    // R8
    dir_excl_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !(xfer_wr && xfer_rd));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !(!$past(addr_stb_n) && addr_stb_n) |=> $stable(reg_idx));

    // R7
    burst_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!cyc_n && !data_cs_n && mode_n) |=> ((xfer_wr || xfer_rd) && (xfer_lanes == '1)));

    // R6
    be_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((xfer_wr || xfer_rd) && $past(data_cs_n)) |-> (xfer_lanes == ~$past(be_n)));

    // R9
    single_pace_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!mode_n && !cyc_n && !$past(cyc_n) && $past(rst_n)) |=> (!xfer_wr && !xfer_rd));

    // R11
    unqualified_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (!cyc_n && data_cs_n && !dev_sel) |=> (!xfer_wr && !xfer_rd));

endmodule

bind hbus_front hbus_front_chk #(
    .LANES (DATA_W / 8),
    .IDX_W (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_stb_n (addr_stb_n),
    .be_n       (be_n),
    .data_cs_n  (data_cs_n),
    .cyc_n      (cyc_n),
    .mode_n     (mode_n),
    .dev_sel    (dev_sel),
    .reg_idx    (reg_idx),
    .xfer_wr    (xfer_wr),
    .xfer_rd    (xfer_rd),
    .xfer_lanes (xfer_lanes)
);

// File: tb/hbus_front_test.sv
module hbus_front_test;
    localparam int N = 5;
    localparam logic [11:0] BASE = 12'h3A5;

    logic        clk = 1'b0;
    logic        rst_n_raw = 1'b1;
    logic [11:0] base_addr = BASE;
    logic [15:1] addr = '0;
    logic        aen = 1'b1;
    logic        addr_stb_n = 1'b1;
    logic [3:0]  be_n = 4'hF;
    logic        data_cs_n = 1'b1;
    logic        cyc_n = 1'b1;
    logic        wr_rd = 1'b0;
    logic        mode_n = 1'b0;
    logic        live_sel, dev_sel, xfer_wr, xfer_rd;
    logic [2:0]  reg_idx, xfer_idx;
    logic [3:0]  xfer_lanes;

    int vectors = 0;
    int errors  = 0;
    bit chk_on  = 1'b0;

    // model state
    int          m_cnt = 0;
    logic        m_stb = 1'b1, m_cyc = 1'b1, m_aen = 1'b1;
    logic [15:1] m_addr = '0;
    logic        m_wr = 0, m_rd = 0;
    logic [3:0]  m_lanes = 0;
    logic [2:0]  m_idx = 0;

    hbus_front uut (
        .clk(clk), .rst_n_raw(rst_n_raw), .base_addr(base_addr), .addr(addr),
        .aen(aen), .addr_stb_n(addr_stb_n), .be_n(be_n), .data_cs_n(data_cs_n),
        .cyc_n(cyc_n), .wr_rd(wr_rd), .mode_n(mode_n), .live_sel(live_sel),
        .dev_sel(dev_sel), .reg_idx(reg_idx), .xfer_wr(xfer_wr), .xfer_rd(xfer_rd),
        .xfer_lanes(xfer_lanes), .xfer_idx(xfer_idx)
    );

    always #10 clk = ~clk;

    function automatic logic exp_dev();
        return !m_aen && (m_addr[15:4] == base_addr);
    endfunction

    task automatic check(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: inputs already driven after the falling edge.
    task automatic step();
        logic act, fire, dsel;
        logic [2:0] ridx;
        string ptag, ltag;
        #1;
        dsel = exp_dev();
        ridx = m_addr[3:1];
        if (chk_on) begin
            check("R2 live_sel", live_sel, !aen && (addr[15:4] == base_addr));
            check("R4 dev_sel", dev_sel, dsel);
            check("R5 reg_idx", reg_idx, ridx);
        end
        act  = (m_cnt == N);
        fire = !cyc_n && (dsel || !data_cs_n) && (mode_n || m_cyc);
        ptag = (cyc_n || !(dsel || !data_cs_n)) ? "R11 pulse" : (mode_n ? "R10 pulse" : "R9 pulse");
        ltag = data_cs_n ? "R6 lanes" : "R7 lanes";
        if (act) begin
            m_stb = 1; m_cyc = 1; m_aen = 1; m_addr = '0;
            m_wr = 0; m_rd = 0; m_lanes = 0; m_idx = 0;
        end else begin
            if (!m_stb && addr_stb_n) begin
                m_addr = addr; m_aen = aen;
            end
            m_stb   = addr_stb_n;
            m_cyc   = cyc_n;
            m_wr    = fire && wr_rd;
            m_rd    = fire && !wr_rd;
            m_lanes = fire ? (data_cs_n ? ~be_n : 4'hF) : 4'h0;
            m_idx   = fire ? ridx : 3'd0;
        end
        if (rst_n_raw) m_cnt = 0;
        else if (m_cnt != N) m_cnt++;
        @(posedge clk);
        #1;
        if (chk_on) begin
            check({ptag, " wr R8"}, xfer_wr, m_wr);
            check({ptag, " rd R8"}, xfer_rd, m_rd);
            check(ltag, xfer_lanes, m_lanes);
            check("R8 idx", xfer_idx, m_idx);
        end
        @(negedge clk);
    endtask

    task automatic latch(logic [15:1] a, logic e);
        addr = a; aen = e; addr_stb_n = 1'b0; step();
        addr_stb_n = 1'b1; step();
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        @(negedge clk);
        // full reset
        rst_n_raw = 1'b0;
        for (int i = 0; i < N + 3; i++) step();
        chk_on = 1'b1;
        step();
        check("R12 reset dev_sel", dev_sel, 0);
        check("R12 reset xfer_wr", xfer_wr, 0);
        check("R12 reset reg_idx", reg_idx, 0);
        rst_n_raw = 1'b1;
        step();
        step();

        // R3: capture, then move the live bus away
        latch({BASE, 3'd5}, 1'b0);
        addr = {~BASE, 3'd2}; aen = 1'b1; step();
        check("R3 held dev_sel", dev_sel, 1);
        check("R3 held reg_idx", reg_idx, 5);
        check("R3 live_sel moved", live_sel, 0);

        // R7 burst with all byte enables off, R10 streaming
        mode_n = 1'b1; data_cs_n = 1'b0; be_n = 4'hF; wr_rd = 1'b1; cyc_n = 1'b0;
        step();
        check("R7 burst lanes", xfer_lanes, 4'hF);
        step();
        check("R10 second pulse", xfer_wr, 1);
        cyc_n = 1'b1; data_cs_n = 1'b1; step();

        // R9 single pacing: two low samples, one pulse
        mode_n = 1'b0; wr_rd = 1'b0; be_n = 4'b1010; cyc_n = 1'b0;
        step();
        check("R9 first rd", xfer_rd, 1);
        check("R6 lanes", xfer_lanes, 4'b0101);
        step();
        check("R9 no repeat", xfer_rd, 0);
        cyc_n = 1'b1; step();

        // R1: short pulse keeps state
        rst_n_raw = 1'b0;
        for (int i = 0; i < N - 1; i++) step();
        rst_n_raw = 1'b1; step(); step();
        check("R1 glitch ignored", dev_sel, 1);
        // R1: long pulse clears state
        rst_n_raw = 1'b0;
        for (int i = 0; i < N + 1; i++) step();
        rst_n_raw = 1'b1; step(); step();
        check("R1 reset taken", dev_sel, 0);

        // R11: not selected, no burst select
        cyc_n = 1'b0; step();
        check("R11 no pulse", xfer_rd | xfer_wr, 0);
        cyc_n = 1'b1; step();

        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(1, 0) == 1) addr[15:4] = BASE;
            else addr[15:4] = 12'($urandom);
            addr[3:1]  = 3'($urandom);
            aen        = ($urandom_range(3, 0) == 0);
            if ($urandom_range(2, 0) == 0) addr_stb_n = ~addr_stb_n;
            be_n       = 4'($urandom);
            data_cs_n  = ($urandom_range(3, 0) != 0);
            if ($urandom_range(2, 0) == 0) cyc_n = ~cyc_n;
            wr_rd      = 1'($urandom);
            if ($urandom_range(15, 0) == 0) mode_n = ~mode_n;
            if ($urandom_range(300, 0) == 0) rst_n_raw = 1'b0;
            else if (!rst_n_raw && $urandom_range(4, 0) == 0) rst_n_raw = 1'b1;
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule